// File: doc/BRIEF.md
# Dual-Mode Serial Port (Asynchronous / Clocked)

This block moves characters of 5 to 8 bits over a pair of data lines, one outbound (`txd`) and one inbound (`rxd`). It runs either as an asynchronous port or as a clocked port. In asynchronous mode each frame is framed by start and stop bits, and the receiver recovers bit timing from a 16x oversampling tick. In clocked mode every bit travels with an explicit clock. The outbound and inbound directions each have their own clock line. When the port is master it generates that clock. When it is slave it follows a clock arriving from outside.

A single bit-rate tick drives all timing. That tick is selected from five sources: a time-base pulse stream (`tb_fast_tick`), that stream divided by two, that stream divided by four, and two timer overflow pulses. The selected tick is the 16x oversampling rate in asynchronous mode and the half-period rate of the generated clock in clocked master mode. Software starts a transmission with `tx_start`. Each direction reports completion with its own single-cycle pulse, `tx_done` or `rx_done`. The receiver keeps the last character, right-aligned, together with a framing flag.

Top module: `dual_serial_port`

## Requirements
- R1: While and after reset, `txd`, `txc_o` and `rxc_o` are 1, `tx_busy`, `tx_done`, `rx_done`, `rx_frame_err` are 0 and `rx_data` is 0.
- R2: In asynchronous mode (`cfg_sync`=0), a transmitted frame consists of a low start bit, then the data bits LSB first, then a high stop bit. Each bit lasts 16 bit-rate ticks, and the line rests high between frames.
- R3: `cfg_len` selects the character length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Only the low bits of `tx_data` are sent, and `rx_data` holds the received bits right-aligned with all upper bits zero.
- R4: `cfg_baud` selects the bit-rate tick. 0 selects every `tb_fast_tick` pulse, 1 every second pulse, 2 every fourth pulse, 3 each `tmr0_ovf` pulse and 4 each `tmr1_ovf` pulse.
- R5: The asynchronous receiver confirms a start bit at its middle (8 ticks after the falling edge is seen). A low pulse shorter than half a bit is discarded without a character.
- R6: The asynchronous receiver samples each data bit at mid-bit. It decodes characters whose bit period deviates from nominal by 3% in either direction.
- R7: `rx_frame_err` is set with `rx_done` when the stop bit samples low. After that, the receiver ignores the line until it returns high. A later good character clears the flag.
- R8: In clocked master mode (`cfg_sync`=1, `cfg_master`=1), `txc_oe` is 1 and `txc_o` idles high. Each tick toggles `txc_o` during a transfer. `txd` takes the next bit on each falling edge, and exactly N rising edges occur for an N-bit character.
- R9: In clocked mode, a `rx_start` pulse arms the receiver, which samples `rxd` on each rising receive clock edge. As master it drives `rxc_o` (with `rxc_oe`=1) for exactly the character length.
- R10: In clocked slave mode (`cfg_master`=0), both clock enables are 0. Transmit shifts on the falling edges of `txc_i`, and receive samples `rxd` on the rising edges of `rxc_i`.
- R11: `tx_done` and `rx_done` are single-cycle pulses, one per character.
- R12: A `tx_start` pulse arriving while `tx_busy` is 1 is ignored: the character in flight is unchanged and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sync | input | 1 | 1 selects clocked mode, 0 asynchronous |
| cfg_master | input | 1 | Clocked mode role: 1 generates the clocks |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_baud | input | 3 | Bit-rate tick source select |
| tb_fast_tick | input | 1 | Time-base pulse at twice the base rate |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tx_start | input | 1 | Start transmission of `tx_data` |
| tx_data | input | 8 | Character to send |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | Transmit-complete pulse |
| txd | output | 1 | Outbound data line |
| txc_o | output | 1 | Generated transmit clock |
| txc_oe | output | 1 | Transmit clock pin drive enable |
| txc_i | input | 1 | Incoming transmit clock (slave) |
| rx_start | input | 1 | Arm clocked-mode reception |
| rxd | input | 1 | Inbound data line |
| rx_data | output | 8 | Last received character, right-aligned |
| rx_frame_err | output | 1 | Stop bit of last character was low |
| rx_done | output | 1 | Receive-complete pulse |
| rxc_o | output | 1 | Generated receive clock |
| rxc_oe | output | 1 | Receive clock pin drive enable |
| rxc_i | input | 1 | Incoming receive clock (slave) |

## Verification
The hardest situations to reach are the receiver's recovery paths. One is a start bit that disappears before its midpoint. Another is a stop bit that stays low long after the point where it is sampled. Both need the inbound line to be shaped cycle by cycle rather than taken from the block's own transmitter. The bench therefore owns a bit-level line driver with an adjustable bit length and stop value. With it the bench produces a quarter-bit glitch, a stop bit held low for several bit times, and frames stretched or shrunk by one core cycle per bit for the rate-tolerance check. Ordinary characters use a loopback from `txd` to `rxd` across every length code.

// File: rtl/sport_pkg.sv
// Shared types for the dual-mode serial port.
package sport_pkg;

    // Bit-rate tick source codes (values are part of the configuration contract)
    typedef enum logic [2:0] {
        BAUD_TB_X2   = 3'd0,
        BAUD_TB_X1   = 3'd1,
        BAUD_TB_HALF = 3'd2,
        BAUD_TMR0    = 3'd3,
        BAUD_TMR1    = 3'd4
    } baud_sel_e;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_STOP   = 3'd3,
        RX_WAITHI = 3'd4,
        RX_SYNC   = 3'd5
    } rx_state_e;

endpackage

// File: rtl/sport_baud.sv
// Bit-rate tick selection.
// Divides the fast time-base pulse by 1, 2 or 4, or passes one of two timer
// overflow pulses, and registers the chosen pulse as a one-cycle tick.
// Assumes every source is already a single-cycle pulse in the clk domain.
module sport_baud
    import sport_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       fast_tick,
    input  logic       tmr0_ovf,
    input  logic       tmr1_ovf,
    output logic       baud_tick
);

    localparam logic [DIV_W-1:0] DIV_ALL = '1;

    logic [DIV_W-1:0] div_q;
    logic             tick_d;
    logic             tick_q;

    // Free-running divider advanced by each fast time-base pulse
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (fast_tick) div_q <= div_q + DIV_W'(1);
    end

    // Pick the tick source named by the select code
    always_comb begin
        case (baud_sel_e'(sel))
            BAUD_TB_X2:   tick_d = fast_tick;
            BAUD_TB_X1:   tick_d = fast_tick & div_q[0];
            BAUD_TB_HALF: tick_d = fast_tick & (div_q == DIV_ALL);
            BAUD_TMR0:    tick_d = tmr0_ovf;
            BAUD_TMR1:    tick_d = tmr1_ovf;
            default:      tick_d = 1'b0;
        endcase
    end

    // Register the tick so downstream logic sees a clean pulse
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    assign baud_tick = tick_q;

    // R4
    tick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(fast_tick | tmr0_ovf | tmr1_ovf));

endmodule

// File: rtl/sport_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is a slow level, so a per-bit synchronizer is sufficient.
module sport_sync #(
    parameter int         WIDTH     = 3,
    parameter int         STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture of the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // Further stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sport_tx.sv
// Transmit engine for both modes.
// Asynchronous: start bit, n_bits data bits LSB first, stop bit, OVERSAMPLE
// ticks per bit. Clocked: the next bit is presented on each falling clock
// edge, and a bit counts as sent on the rising edge that follows. As master
// the clock comes from baud ticks; as slave it comes from ext_clk.
// Assumes the configuration is held constant while busy.
module sport_tx
    import sport_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              master,
    input  logic [CNT_W-1:0]  n_bits,
    input  logic              baud_tick,
    input  logic              ext_clk,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              clk_out,
    output logic              busy,
    output logic              done
);

    localparam int               TICK_W    = $clog2(OVERSAMPLE);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

    tx_state_e         state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [TICK_W-1:0] tick_q;
    logic              txd_q, clk_q, done_q, fell_q, ext_prev_q;
    logic              ev_fall, ev_rise, ext_rise, ext_fall;

    // Edge detection on the synchronized slave clock
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev_q <= 1'b1;
        else        ext_prev_q <= ext_clk;
    end

    assign ext_rise = ext_clk & ~ext_prev_q;
    assign ext_fall = ~ext_clk & ext_prev_q;

    // Clock events in clocked mode, from the own clock or the external one
    always_comb begin
        ev_fall = sync_mode & (master ? (baud_tick & clk_q)  : ext_fall);
        ev_rise = sync_mode & (master ? (baud_tick & ~clk_q) : ext_rise);
    end

    // Frame sequencing and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            tick_q   <= '0;
            txd_q    <= 1'b1;
            clk_q    <= 1'b1;
            done_q   <= 1'b0;
            fell_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                TX_IDLE: begin
                    if (start) begin
                        state_q  <= TX_RUN;
                        shreg_q  <= data;
                        bitcnt_q <= '0;
                        tick_q   <= '0;
                        fell_q   <= 1'b0;
                        if (!sync_mode) txd_q <= 1'b0;
                    end
                end
                TX_RUN: begin
                    if (!sync_mode) begin
                        if (baud_tick) begin
                            tick_q <= tick_q + TICK_W'(1);
                            if (tick_q == LAST_TICK) begin
                                bitcnt_q <= bitcnt_q + ONE;
                                if (bitcnt_q == n_bits + ONE) begin
                                    state_q <= TX_IDLE;
                                    done_q  <= 1'b1;
                                end else if (bitcnt_q < n_bits) begin
                                    txd_q   <= shreg_q[0];
                                    shreg_q <= shreg_q >> 1;
                                end else begin
                                    txd_q <= 1'b1;
                                end
                            end
                        end
                    end else if (ev_fall) begin
                        txd_q   <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        fell_q  <= 1'b1;
                        if (master) clk_q <= 1'b0;
                    end else if (ev_rise) begin
                        if (master) clk_q <= 1'b1;
                        if (fell_q) begin
                            fell_q   <= 1'b0;
                            bitcnt_q <= bitcnt_q + ONE;
                            if (bitcnt_q == n_bits - ONE) begin
                                state_q <= TX_IDLE;
                                done_q  <= 1'b1;
                                txd_q   <= 1'b1;
                            end
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign txd     = txd_q;
    assign clk_out = clk_q;
    assign busy    = (state_q == TX_RUN);
    assign done    = done_q;

    // R11
    tx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> txd_q);

    // R12
    tx_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TX_RUN) |-> $past(start));

    // R8
    tx_clk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(clk_q));

endmodule

// File: rtl/sport_rx.sv
// Receive engine for both modes.
// Asynchronous: hunts for a low line, confirms the start bit at its middle,
// samples each data bit and the stop bit at mid-bit using OVERSAMPLE ticks
// per bit, and waits for a high line after a framing error. Clocked: armed
// by start, samples on each rising receive clock edge (own or external).
// Assumes rxd and ext_clk are synchronized and the configuration is static.
module sport_rx
    import sport_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              master,
    input  logic [CNT_W-1:0]  n_bits,
    input  logic              baud_tick,
    input  logic              rxd_s,
    input  logic              ext_clk,
    input  logic              start,
    output logic [DATA_W-1:0] data,
    output logic              frame_err,
    output logic              done,
    output logic              clk_out
);

    localparam int               TICK_W    = $clog2(OVERSAMPLE);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);
    localparam logic [TICK_W-1:0] MID_TICK  = TICK_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0]  DW_C      = CNT_W'(DATA_W);

    rx_state_e         state_q;
    logic [DATA_W-1:0] shreg_q, data_q, shift_nxt;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [TICK_W-1:0] tick_q;
    logic              ferr_q, done_q, clk_q, ext_prev_q, sample_ev;

    function automatic logic [DATA_W-1:0] align(input logic [DATA_W-1:0] v,
                                                input logic [CNT_W-1:0]  n);
        return v >> (DW_C - n);
    endfunction

    // Edge memory for the synchronized slave clock
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev_q <= 1'b1;
        else        ext_prev_q <= ext_clk;
    end

    // Rising-edge sample event and shift-in value for clocked mode
    always_comb begin
        sample_ev = master ? (baud_tick & ~clk_q) : (ext_clk & ~ext_prev_q);
        shift_nxt = {rxd_s, shreg_q[DATA_W-1:1]};
    end

    // Receive sequencing, sampling and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            shreg_q  <= '0;
            data_q   <= '0;
            bitcnt_q <= '0;
            tick_q   <= '0;
            ferr_q   <= 1'b0;
            done_q   <= 1'b0;
            clk_q    <= 1'b1;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (sync_mode) begin
                        if (start) begin
                            state_q  <= RX_SYNC;
                            bitcnt_q <= '0;
                        end
                    end else if (!rxd_s) begin
                        state_q <= RX_START;
                        tick_q  <= '0;
                    end
                end
                RX_START: begin
                    if (baud_tick) begin
                        tick_q <= tick_q + TICK_W'(1);
                        if (tick_q == MID_TICK) begin
                            if (rxd_s) begin
                                state_q <= RX_IDLE;
                            end else begin
                                state_q  <= RX_DATA;
                                tick_q   <= '0;
                                bitcnt_q <= '0;
                            end
                        end
                    end
                end
                RX_DATA: begin
                    if (baud_tick) begin
                        tick_q <= tick_q + TICK_W'(1);
                        if (tick_q == LAST_TICK) begin
                            shreg_q  <= shift_nxt;
                            bitcnt_q <= bitcnt_q + ONE;
                            if (bitcnt_q == n_bits - ONE) state_q <= RX_STOP;
                        end
                    end
                end
                RX_STOP: begin
                    if (baud_tick) begin
                        tick_q <= tick_q + TICK_W'(1);
                        if (tick_q == LAST_TICK) begin
                            data_q  <= align(shreg_q, n_bits);
                            ferr_q  <= ~rxd_s;
                            done_q  <= 1'b1;
                            state_q <= rxd_s ? RX_IDLE : RX_WAITHI;
                        end
                    end
                end
                RX_WAITHI: begin
                    if (rxd_s) state_q <= RX_IDLE;
                end
                RX_SYNC: begin
                    if (master && baud_tick && clk_q) clk_q <= 1'b0;
                    if (sample_ev) begin
                        if (master) clk_q <= 1'b1;
                        shreg_q  <= shift_nxt;
                        bitcnt_q <= bitcnt_q + ONE;
                        if (bitcnt_q == n_bits - ONE) begin
                            data_q  <= align(shift_nxt, n_bits);
                            ferr_q  <= 1'b0;
                            done_q  <= 1'b1;
                            state_q <= RX_IDLE;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign data      = data_q;
    assign frame_err = ferr_q;
    assign done      = done_q;
    assign clk_out   = clk_q;

    // R11
    rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    rx_ferr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr_q) |-> done_q);

    // R3
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((data_q >> n_bits) == '0));

    // R9
    rx_clk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(clk_q));

endmodule

// File: rtl/dual_serial_port.sv
// Dual-mode serial port top level.
// Combines tick selection, input synchronization, the transmit engine and
// the receive engine. Clock pin drivers are enabled only in clocked master
// mode. Assumes configuration inputs change only while both engines are idle.
module dual_serial_port
    import sport_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_LEN    = 5,
    parameter int OVERSAMPLE = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sync,
    input  logic              cfg_master,
    input  logic [1:0]        cfg_len,
    input  logic [2:0]        cfg_baud,
    input  logic              tb_fast_tick,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              txd,
    output logic              txc_o,
    output logic              txc_oe,
    input  logic              txc_i,
    input  logic              rx_start,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_frame_err,
    output logic              rx_done,
    output logic              rxc_o,
    output logic              rxc_oe,
    input  logic              rxc_i
);

    localparam int CNT_W = $clog2(DATA_W + 2);

    logic [CNT_W-1:0] n_bits;
    logic             baud_tick;
    logic [2:0]       pins_s;

    assign n_bits = CNT_W'(MIN_LEN) + CNT_W'(cfg_len);

    sport_baud #(.DIV_W(2)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (cfg_baud),
        .fast_tick (tb_fast_tick),
        .tmr0_ovf  (tmr0_ovf),
        .tmr1_ovf  (tmr1_ovf),
        .baud_tick (baud_tick)
    );

    sport_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({txc_i, rxc_i, rxd}),
        .sync_out (pins_s)
    );

    sport_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (cfg_sync),
        .master    (cfg_master),
        .n_bits    (n_bits),
        .baud_tick (baud_tick),
        .ext_clk   (pins_s[2]),
        .start     (tx_start),
        .data      (tx_data),
        .txd       (txd),
        .clk_out   (txc_o),
        .busy      (tx_busy),
        .done      (tx_done)
    );

    sport_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (cfg_sync),
        .master    (cfg_master),
        .n_bits    (n_bits),
        .baud_tick (baud_tick),
        .rxd_s     (pins_s[0]),
        .ext_clk   (pins_s[1]),
        .start     (rx_start),
        .data      (rx_data),
        .frame_err (rx_frame_err),
        .done      (rx_done),
        .clk_out   (rxc_o)
    );

    assign txc_oe = cfg_sync & cfg_master;
    assign rxc_oe = cfg_sync & cfg_master;

    // R10
    clk_oe_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txc_oe || rxc_oe) |-> (cfg_sync && cfg_master));

endmodule

// File: tb/test_dual_serial_port.sv
module test_dual_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sync = 1'b0, cfg_master = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [2:0] cfg_baud = 3'd0;
    logic       tb_fast_tick = 1'b0, tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
    logic       tx_start = 1'b0, rx_start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       txc_i = 1'b1, rxc_i = 1'b1, rxd_drv = 1'b1, loop_en = 1'b0;
    logic       tx_busy, tx_done, txd, txc_o, txc_oe;
    logic [7:0] rx_data;
    logic       rx_frame_err, rx_done, rxc_o, rxc_oe, rxd;

    int n_chk = 0, n_fail = 0;
    int tx_cnt = 0, rx_cnt = 0, wide = 0;
    logic tx_prev = 1'b0, rx_prev = 1'b0;
    bit finished = 1'b0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #10 clk = ~clk;

    dual_serial_port i_dual_serial_port (
        .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_master(cfg_master),
        .cfg_len(cfg_len), .cfg_baud(cfg_baud), .tb_fast_tick(tb_fast_tick),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tx_start(tx_start),
        .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done), .txd(txd),
        .txc_o(txc_o), .txc_oe(txc_oe), .txc_i(txc_i), .rx_start(rx_start),
        .rxd(rxd), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
        .rx_done(rx_done), .rxc_o(rxc_o), .rxc_oe(rxc_oe), .rxc_i(rxc_i)
    );

    // Tick sources: time base every 2 cycles, timer 0 every 3, timer 1 every 5
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c++;
            tb_fast_tick = (c % 2 == 0);
            tmr0_ovf     = (c % 3 == 0);
            tmr1_ovf     = (c % 5 == 0);
        end
    end

    // Completion pulse counting and width monitor (R11)
    always @(negedge clk) begin
        if (tx_done) tx_cnt++;
        if (rx_done) rx_cnt++;
        if ((tx_done && tx_prev) || (rx_done && rx_prev)) wide++;
        tx_prev = tx_done;
        rx_prev = rx_done;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx(input logic [7:0] d);
        @(negedge clk);
        tx_data = d;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
    endtask

    task automatic wait_rx(input int base, input int limit);
        for (int k = 0; k < limit && rx_cnt == base; k++) @(negedge clk);
    endtask

    task automatic wait_tx_idle();
        for (int k = 0; k < 20000 && tx_busy; k++) @(negedge clk);
    endtask

    // Shape an asynchronous frame on rxd with a given bit length and stop value
    task automatic uart_send(input logic [7:0] d, input int nb, input int bitc, input logic stopv);
        @(negedge clk);
        rxd_drv = 1'b0;
        wait_cycles(bitc);
        for (int b = 0; b < nb; b++) begin
            rxd_drv = d[b];
            wait_cycles(bitc);
        end
        rxd_drv = stopv;
        wait_cycles(bitc);
    endtask

    // Length of the low start bit of a 0xFF character
    task automatic measure_start(output int w);
        w = 0;
        for (int k = 0; k < 4000 && txd; k++) @(negedge clk);
        while (!txd && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    // {len code, data} loopback vectors for R3
    localparam logic [9:0] VECS [8] = '{
        {2'd0, 8'h15}, {2'd0, 8'hFF}, {2'd1, 8'h2A}, {2'd1, 8'hC0},
        {2'd2, 8'h55}, {2'd2, 8'hFE}, {2'd3, 8'hA5}, {2'd3, 8'h00}
    };

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base, tbase, w, nb;
        logic [7:0] got, mask;

        // R1 reset state
        wait_cycles(4);
        check("R1 txd", txd, 1);
        check("R1 txc_o", txc_o, 1);
        check("R1 rxc_o", rxc_o, 1);
        check("R1 busy", tx_busy, 0);
        check("R1 done", {tx_done, rx_done}, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 ferr", rx_frame_err, 0);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(4);
        check("R1 txd after", txd, 1);
        check("R1 oe", {txc_oe, rxc_oe}, 0);

        // R3 loopback vector walk, every length code
        loop_en = 1'b1;
        foreach (VECS[i]) begin
            cfg_len = VECS[i][9:8];
            nb = 5 + int'(cfg_len);
            mask = 8'((1 << nb) - 1);
            base = rx_cnt;
            tbase = tx_cnt;
            pulse_tx(VECS[i][7:0]);
            wait_rx(base, 4000);
            check("R3 rx_data", rx_data, VECS[i][7:0] & mask);
            wait_tx_idle();
            wait_cycles(40);
            check("R3 tx_done count", tx_cnt - tbase, 1);
            check("R3 rx_done count", rx_cnt - base, 1);
        end

        // R2 frame shape bit by bit: 6 bits, data 0x2D, 32 cycles per bit
        cfg_len = 2'd1;
        loop_en = 1'b0;
        pulse_tx(8'h2D);
        for (int k = 0; k < 4000 && txd; k++) @(negedge clk);
        wait_cycles(16);
        check("R2 start bit", txd, 0);
        for (int b = 0; b < 6; b++) begin
            wait_cycles(32);
            check("R2 data bit", txd, (8'h2D >> b) & 1);
        end
        wait_cycles(32);
        check("R2 stop bit", txd, 1);
        wait_tx_idle();
        check("R2 idle high", txd, 1);

        // R4 tick source selection via start-bit width
        cfg_len = 2'd3;
        for (int s = 0; s < 5; s++) begin
            int per;
            per = (s == 0) ? 2 : (s == 1) ? 4 : (s == 2) ? 8 : (s == 3) ? 3 : 5;
            cfg_baud = 3'(s);
            wait_cycles(10);
            pulse_tx(8'hFF);
            measure_start(w);
            check_range("R4 start width", w, 16 * per - per, 16 * per + per);
            wait_tx_idle();
        end
        cfg_baud = 3'd0;

        // R5 short glitch is not a start bit
        wait_cycles(20);
        base = rx_cnt;
        @(negedge clk) rxd_drv = 1'b0;
        wait_cycles(8);
        rxd_drv = 1'b1;
        wait_cycles(300);
        check("R5 glitch ignored", rx_cnt - base, 0);
        uart_send(8'h6B, 8, 32, 1'b1);
        wait_rx(base, 200);
        check("R5 frame after glitch", rx_data, 8'h6B);

        // R6 bit-rate tolerance, about -3% and +3%
        wait_cycles(40);
        base = rx_cnt;
        uart_send(8'hC3, 8, 31, 1'b1);
        wait_rx(base, 200);
        check("R6 fast sender", rx_data, 8'hC3);
        wait_cycles(40);
        base = rx_cnt;
        uart_send(8'h3C, 8, 33, 1'b1);
        wait_rx(base, 200);
        check("R6 slow sender", rx_data, 8'h3C);

        // R7 framing error, line stays low, then recovery
        wait_cycles(40);
        base = rx_cnt;
        uart_send(8'h81, 8, 32, 1'b0);
        wait_cycles(100);
        check("R7 ferr set", rx_frame_err, 1);
        check("R7 one char only", rx_cnt - base, 1);
        rxd_drv = 1'b1;
        wait_cycles(40);
        base = rx_cnt;
        uart_send(8'h5A, 8, 32, 1'b1);
        wait_rx(base, 200);
        check("R7 ferr cleared", rx_frame_err, 0);
        check("R7 data after recovery", rx_data, 8'h5A);

        // R12 start while busy is ignored
        loop_en = 1'b1;
        wait_cycles(40);
        base = rx_cnt;
        tbase = tx_cnt;
        pulse_tx(8'h81);
        wait_cycles(40);
        pulse_tx(8'h7E);
        wait_rx(base, 4000);
        check("R12 first char kept", rx_data, 8'h81);
        wait_tx_idle();
        wait_cycles(600);
        check("R12 single tx_done", tx_cnt - tbase, 1);
        check("R12 single rx_done", rx_cnt - base, 1);
        loop_en = 1'b0;

        // R8 clocked master transmit, tick every 4 cycles
        cfg_sync = 1'b1;
        cfg_master = 1'b1;
        cfg_baud = 3'd1;
        cfg_len = 2'd3;
        wait_cycles(4);
        check("R8 txc_oe", txc_oe, 1);
        check("R8 clock idle high", txc_o, 1);
        tbase = tx_cnt;
        got = 8'h00;
        pulse_tx(8'hA5);
        for (int b = 0; b < 8; b++) begin
            @(posedge txc_o);
            got[b] = txd;
        end
        wait_tx_idle();
        wait_cycles(30);
        check("R8 master tx data", got, 8'hA5);
        check("R8 clock high after", txc_o, 1);
        check("R8 tx_done", tx_cnt - tbase, 1);

        // R9 clocked master receive, 7 bits
        cfg_len = 2'd2;
        check("R9 rxc_oe", rxc_oe, 1);
        base = rx_cnt;
        pulse_rx();
        for (int b = 0; b < 7; b++) begin
            @(negedge rxc_o);
            rxd_drv = (8'h3C >> b) & 1;
        end
        wait_rx(base, 200);
        check("R9 master rx data", rx_data, 8'h3C);
        check("R9 ferr clear", rx_frame_err, 0);
        wait_cycles(30);
        check("R9 rxc_o idle", rxc_o, 1);
        rxd_drv = 1'b1;

        // R10 clocked slave transmit and receive
        cfg_master = 1'b0;
        cfg_len = 2'd3;
        wait_cycles(4);
        check("R10 oe off", {txc_oe, rxc_oe}, 0);
        tbase = tx_cnt;
        got = 8'h00;
        pulse_tx(8'h96);
        for (int b = 0; b < 8; b++) begin
            txc_i = 1'b0;
            wait_cycles(6);
            got[b] = txd;
            txc_i = 1'b1;
            wait_cycles(6);
        end
        wait_cycles(6);
        check("R10 slave tx data", got, 8'h96);
        check("R10 slave tx_done", tx_cnt - tbase, 1);
        cfg_len = 2'd0;
        base = rx_cnt;
        pulse_rx();
        for (int b = 0; b < 5; b++) begin
            rxc_i = 1'b0;
            rxd_drv = (8'h13 >> b) & 1;
            wait_cycles(6);
            rxc_i = 1'b1;
            wait_cycles(6);
        end
        wait_rx(base, 50);
        check("R10 slave rx data", rx_data, 8'h13);
        rxd_drv = 1'b1;

        // R11 every completion pulse was one cycle wide
        check("R11 pulse width", wide, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule